// File: doc/BRIEF.md
# Broadcast Message Receiver with Identifier Acceptance Filter

This block listens to a shared, broadcast serial line and rebuilds whole messages from it. The line carries byte-synchronous NRZ characters. Each one has a dominant (0) start bit, eight data bits sent least significant first, and a recessive (1) stop bit. The line rests recessive when idle. Every bit lasts a fixed number of clock cycles (16 by default), and the block decides each bit by a majority vote over the samples around mid-bit. Gaps of any length between characters are allowed.

Characters are assembled into messages. A message is a start marker byte, one or two identifier bytes, zero or more payload bytes, and an end marker byte. The identifier names the message content, not a destination. The block therefore matches it against a host-written acceptance table of value/mask entries. Only accepted messages reach the host, as a byte stream with first-item and last-item markers plus an abort marker. The block also reports framing errors and length overruns. It does not interpret the payload.

Top module: `msgrx_top`

## Requirements
- R1: A character is a dominant (0) start bit, 8 data bits least significant first, and a recessive (1) stop bit, each OSR (16) clock cycles long, with the line idle at 1. A high-to-low transition seen while idle starts a character.
- R2: Each data bit and stop bit takes the majority of samples 6 to 10 of the bit (sample 0 is its first cycle). Corruption of up to 8 of the 16 samples of a bit, two of them inside the voting window, does not change the received byte.
- R3: If the line is back at 1 on sample 8 of a start bit, the start is treated as noise: no byte and no error is produced, and reception resumes at the next transition.
- R4: For an accepted message, the stream gives one first item (out_sop_o=1, data = last identifier byte, out_id_o = identifier), then one item per payload byte, then one last item (out_eop_o=1, data = end code). The abort marker never coincides with an item.
- R5: With id_two_i=0 the identifier is {8'h00, ID byte}. With id_two_i=1 it is {first ID byte, second ID byte}. id_two_i is taken when the first identifier byte arrives.
- R6: A message is accepted when at least one enabled table entry satisfies ((identifier XOR value) AND mask) == 0, where mask bit 1 means "compare". Rejected messages produce no stream output. After reset all entries are disabled.
- R7: Idle time of any length between the characters of a message does not disturb it.
- R8: Outside a message, characters other than the start code are ignored.
- R9: A stop bit voted dominant pulses frm_err_o for one cycle and discards the message in progress (out_abort_o pulses if it was accepted). Bytes up to the next start code are then ignored.
- R10: A start code received before the end code drops the partial message (out_abort_o pulses if it was accepted) and starts a new one.
- R11: A payload byte beyond MAX_LEN (8) pulses ovr_err_o, discards the message (out_abort_o pulses if it was accepted), and ignores bytes up to the next start code. Exactly MAX_LEN payload bytes are accepted.
- R12: After reset no stream item, abort or error flag is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Sampled bus line, 0 dominant |
| id_two_i | input | 1 | 1: two identifier bytes per message |
| flt_wr_i | input | 1 | Write one acceptance table entry |
| flt_idx_i | input | 2 | Entry index for the write |
| flt_en_i | input | 1 | Entry enable |
| flt_val_i | input | 16 | Entry identifier value |
| flt_mask_i | input | 16 | Entry compare mask |
| out_valid_o | output | 1 | Stream item valid |
| out_data_o | output | 8 | Stream item byte |
| out_sop_o | output | 1 | Item is the first of a message |
| out_eop_o | output | 1 | Item is the last of a message |
| out_abort_o | output | 1 | Accepted message discarded |
| out_id_o | output | 16 | Identifier of the last accepted message |
| frm_err_o | output | 1 | Framing error pulse |
| ovr_err_o | output | 1 | Length overrun pulse |

## Verification
The hardest case to reach from the ports is a message that has already been accepted and streamed in part, and is then discarded. The three ways in are a dominant stop bit, a second start code, or one payload byte too many. In each case the bench must see exactly one abort and no end item. The bench builds these sequences by sending a matching identifier first, then shaping the line bit by bit: it holds the stop bit low, inserts a start code early, or sends MAX_LEN+1 payload bytes. It also drives individual oversamples to corrupt samples inside and outside the voting window. Acceptance is swept over all 256 single-byte identifiers against a table mixing masked, exact and disabled entries.

// File: rtl/msgrx_pkg.sv
package msgrx_pkg;
    localparam int IDW = 16;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_st_e;

    typedef enum logic [1:0] {
        FR_HUNT,
        FR_ID1,
        FR_ID2,
        FR_DATA
    } fr_st_e;

    typedef struct packed {
        logic           en;
        logic [IDW-1:0] val;
        logic [IDW-1:0] mask;
    } flt_ent_t;
endpackage

// File: rtl/msgrx_bitrx.sv
module msgrx_bitrx
    import msgrx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    output logic       vld_o,
    output logic [7:0] byte_o,
    output logic       ferr_o
);
    localparam int CW    = $clog2(OSR);
    localparam int MID   = OSR / 2;
    localparam int VLO   = MID - 2;
    localparam int VHI   = MID + 2;
    localparam int VOTEN = VHI - VLO + 1;
    localparam int MAJ   = VOTEN / 2 + 1;

    localparam logic [CW-1:0] MID_C  = CW'(MID);
    localparam logic [CW-1:0] VLO_C  = CW'(VLO);
    localparam logic [CW-1:0] VHI_C  = CW'(VHI);
    localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);

    typedef struct packed {
        rx_st_e     st;
        logic [CW-1:0] cnt;
        logic [2:0] bitn;
        logic [2:0] ones;
        logic [7:0] shreg;
        logic       vld;
        logic [7:0] data;
        logic       ferr;
    } bitrx_s;

    bitrx_s q, d;
    logic       in_win;
    logic [2:0] ones_nx;
    logic       vote;

    always_comb begin
        d       = q;
        d.vld   = 1'b0;
        d.ferr  = 1'b0;
        in_win  = (q.cnt >= VLO_C) && (q.cnt <= VHI_C);
        ones_nx = q.ones + {2'b00, (in_win & rx_i)};
        vote    = (ones_nx >= 3'(MAJ));
        case (q.st)
            RX_IDLE: begin
                if (!rx_i) begin
                    d.st   = RX_START;
                    d.cnt  = CW'(1);
                    d.ones = '0;
                end
            end
            RX_START: begin
                d.cnt = q.cnt + 1'b1;
                if ((q.cnt == MID_C) && rx_i) begin
                    d.st = RX_IDLE;
                end else if (q.cnt == LAST_C) begin
                    d.st   = RX_DATA;
                    d.cnt  = '0;
                    d.bitn = '0;
                    d.ones = '0;
                end
            end
            RX_DATA: begin
                d.ones = ones_nx;
                d.cnt  = q.cnt + 1'b1;
                if (q.cnt == LAST_C) begin
                    d.shreg = {vote, q.shreg[7:1]};
                    d.bitn  = q.bitn + 1'b1;
                    d.ones  = '0;
                    d.cnt   = '0;
                    if (q.bitn == 3'd7) begin
                        d.st = RX_STOP;
                    end
                end
            end
            default: begin
                d.ones = ones_nx;
                d.cnt  = q.cnt + 1'b1;
                if (q.cnt == VHI_C) begin
                    d.vld  = 1'b1;
                    d.data = q.shreg;
                    d.ferr = !vote;
                    d.st   = RX_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign vld_o  = q.vld;
    assign byte_o = q.data;
    assign ferr_o = q.ferr;

    // R1: a character spans many cycles, so byte strobes are never adjacent
    assert_byte_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o);
    // R3: a start that survives past mid-bit saw a dominant line at mid-bit
    assert_start_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_START && q.cnt == MID_C && rx_i) |=> (q.st == RX_IDLE));
endmodule

// File: rtl/msgrx_idfilt.sv
module msgrx_idfilt
    import msgrx_pkg::*;
#(
    parameter int NENT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic [$clog2(NENT)-1:0] idx_i,
    input  logic                    en_i,
    input  logic [IDW-1:0]          val_i,
    input  logic [IDW-1:0]          mask_i,
    input  logic [IDW-1:0]          ident_i,
    output logic                    match_o
);
    flt_ent_t [NENT-1:0] tab_q, tab_d;
    logic     [NENT-1:0] hit;

    always_comb begin
        tab_d = tab_q;
        if (wr_i) begin
            tab_d[idx_i] = '{en: en_i, val: val_i, mask: mask_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    for (genvar g = 0; g < NENT; g++) begin : g_cmp
        assign hit[g] = tab_q[g].en &&
                        (((ident_i ^ tab_q[g].val) & tab_q[g].mask) == '0);
    end

    assign match_o = |hit;

    // R6: a freshly written disabled entry cannot hit
    assert_dis_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !en_i) |=> !hit[$past(idx_i)]);
endmodule

// File: rtl/msgrx_framer.sv
module msgrx_framer
    import msgrx_pkg::*;
#(
    parameter int         MAX_LEN  = 8,
    parameter logic [7:0] SOM_CODE = 8'hA5,
    parameter logic [7:0] EOM_CODE = 8'h5A
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vld_i,
    input  logic [7:0]     byte_i,
    input  logic           ferr_i,
    input  logic           id_two_i,
    input  logic           match_i,
    output logic [IDW-1:0] cand_o,
    output logic           out_valid_o,
    output logic [7:0]     out_data_o,
    output logic           out_sop_o,
    output logic           out_eop_o,
    output logic           out_abort_o,
    output logic [IDW-1:0] out_id_o,
    output logic           frm_err_o,
    output logic           ovr_err_o
);
    localparam int LW = $clog2(MAX_LEN + 1);
    localparam logic [LW-1:0] MAX_C = LW'(MAX_LEN);

    typedef struct packed {
        fr_st_e         st;
        logic [7:0]     id1;
        logic [IDW-1:0] ident;
        logic           acc;
        logic [LW-1:0]  cnt;
        logic           ov;
        logic [7:0]     od;
        logic           osop;
        logic           oeop;
        logic           oab;
        logic           ferr;
        logic           oerr;
    } fr_s;

    fr_s            q, d;
    logic           id_done;
    logic [IDW-1:0] cand;

    always_comb begin
        d       = q;
        d.ov    = 1'b0;
        d.osop  = 1'b0;
        d.oeop  = 1'b0;
        d.oab   = 1'b0;
        d.ferr  = 1'b0;
        d.oerr  = 1'b0;
        id_done = 1'b0;
        cand    = (q.st == FR_ID2) ? {q.id1, byte_i} : {8'h00, byte_i};
        if (vld_i) begin
            if (ferr_i) begin
                d.ferr = 1'b1;
                d.oab  = q.acc;
                d.acc  = 1'b0;
                d.st   = FR_HUNT;
            end else if (byte_i == SOM_CODE) begin
                d.oab = q.acc;
                d.acc = 1'b0;
                d.st  = FR_ID1;
            end else begin
                case (q.st)
                    FR_ID1: begin
                        if (id_two_i) begin
                            d.id1 = byte_i;
                            d.st  = FR_ID2;
                        end else begin
                            id_done = 1'b1;
                        end
                    end
                    FR_ID2: id_done = 1'b1;
                    FR_DATA: begin
                        if (byte_i == EOM_CODE) begin
                            d.ov   = q.acc;
                            d.oeop = q.acc;
                            d.od   = q.acc ? byte_i : q.od;
                            d.acc  = 1'b0;
                            d.st   = FR_HUNT;
                        end else if (q.cnt == MAX_C) begin
                            d.oerr = 1'b1;
                            d.oab  = q.acc;
                            d.acc  = 1'b0;
                            d.st   = FR_HUNT;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                            d.ov  = q.acc;
                            d.od  = q.acc ? byte_i : q.od;
                        end
                    end
                    default: ;
                endcase
                if (id_done) begin
                    d.st  = FR_DATA;
                    d.cnt = '0;
                    d.acc = match_i;
                    if (match_i) begin
                        d.ident = cand;
                        d.ov    = 1'b1;
                        d.osop  = 1'b1;
                        d.od    = byte_i;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: FR_HUNT, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cand_o      = cand;
    assign out_valid_o = q.ov;
    assign out_data_o  = q.od;
    assign out_sop_o   = q.osop;
    assign out_eop_o   = q.oeop;
    assign out_abort_o = q.oab;
    assign out_id_o    = q.ident;
    assign frm_err_o   = q.ferr;
    assign ovr_err_o   = q.oerr;

    // R4: stream items only follow a received byte
    assert_item_after_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(vld_i));
    // R4: an item is never both first and last
    assert_sop_eop_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !(out_sop_o && out_eop_o));
    // R10: abort never coincides with an item
    assert_abort_no_item_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_abort_o |-> !out_valid_o);
    // R9: framing error is a single-cycle pulse
    assert_frm_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err_o |=> !frm_err_o);
    // R11: payload count never exceeds the limit; overrun is a pulse
    assert_len_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= MAX_C);
    assert_ovr_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_err_o |=> !ovr_err_o);
endmodule

// File: rtl/msgrx_top.sv
module msgrx_top
    import msgrx_pkg::*;
#(
    parameter int         OSR      = 16,
    parameter int         MAX_LEN  = 8,
    parameter int         FLT_N    = 4,
    parameter logic [7:0] SOM_CODE = 8'hA5,
    parameter logic [7:0] EOM_CODE = 8'h5A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_i,
    input  logic                     id_two_i,
    input  logic                     flt_wr_i,
    input  logic [$clog2(FLT_N)-1:0] flt_idx_i,
    input  logic                     flt_en_i,
    input  logic [15:0]              flt_val_i,
    input  logic [15:0]              flt_mask_i,
    output logic                     out_valid_o,
    output logic [7:0]               out_data_o,
    output logic                     out_sop_o,
    output logic                     out_eop_o,
    output logic                     out_abort_o,
    output logic [15:0]              out_id_o,
    output logic                     frm_err_o,
    output logic                     ovr_err_o
);
    logic           b_vld;
    logic [7:0]     b_data;
    logic           b_ferr;
    logic [IDW-1:0] cand;
    logic           match;

    msgrx_bitrx #(.OSR(OSR)) u_bitrx (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_i),
        .vld_o  (b_vld),
        .byte_o (b_data),
        .ferr_o (b_ferr)
    );

    msgrx_idfilt #(.NENT(FLT_N)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (flt_wr_i),
        .idx_i   (flt_idx_i),
        .en_i    (flt_en_i),
        .val_i   (flt_val_i),
        .mask_i  (flt_mask_i),
        .ident_i (cand),
        .match_o (match)
    );

    msgrx_framer #(
        .MAX_LEN  (MAX_LEN),
        .SOM_CODE (SOM_CODE),
        .EOM_CODE (EOM_CODE)
    ) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .vld_i       (b_vld),
        .byte_i      (b_data),
        .ferr_i      (b_ferr),
        .id_two_i    (id_two_i),
        .match_i     (match),
        .cand_o      (cand),
        .out_valid_o (out_valid_o),
        .out_data_o  (out_data_o),
        .out_sop_o   (out_sop_o),
        .out_eop_o   (out_eop_o),
        .out_abort_o (out_abort_o),
        .out_id_o    (out_id_o),
        .frm_err_o   (frm_err_o),
        .ovr_err_o   (ovr_err_o)
    );

    // R9: a framing error never arrives together with a stream item
    assert_frm_no_item_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err_o |-> !out_valid_o);
endmodule

// File: tb/msgrx_top_tb_top.sv
`timescale 1ns/1ps
module msgrx_top_tb_top;
    localparam logic [7:0] SOM = 8'hA5;
    localparam logic [7:0] EOM = 8'h5A;
    localparam int T_SOP = 1, T_DAT = 2, T_EOP = 3, T_ABT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b1;
    logic id_two = 1'b0;
    logic flt_wr = 1'b0;
    logic [1:0] flt_idx = '0;
    logic flt_en = 1'b0;
    logic [15:0] flt_val = '0, flt_mask = '0;
    logic out_valid, out_sop, out_eop, out_abort, frm_err, ovr_err;
    logic [7:0] out_data;
    logic [15:0] out_id;

    always #2 clk = ~clk;

    msgrx_top dut_i (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .id_two_i(id_two),
        .flt_wr_i(flt_wr), .flt_idx_i(flt_idx), .flt_en_i(flt_en),
        .flt_val_i(flt_val), .flt_mask_i(flt_mask),
        .out_valid_o(out_valid), .out_data_o(out_data), .out_sop_o(out_sop),
        .out_eop_o(out_eop), .out_abort_o(out_abort), .out_id_o(out_id),
        .frm_err_o(frm_err), .ovr_err_o(ovr_err)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    int ev_n = 0, frm_cnt = 0, ovr_cnt = 0;
    int ev_t [0:2047];
    logic [7:0]  ev_d  [0:2047];
    logic [15:0] ev_id [0:2047];

    // bench copy of the acceptance table
    bit          m_en  [0:3];
    logic [15:0] m_val [0:3];
    logic [15:0] m_msk [0:3];

    always @(negedge clk) begin
        if (rst_n && ev_n < 2040) begin
            if (out_valid) begin
                ev_t[ev_n]  = out_sop ? T_SOP : (out_eop ? T_EOP : T_DAT);
                ev_d[ev_n]  = out_data;
                ev_id[ev_n] = out_id;
                ev_n++;
            end
            if (out_abort) begin
                ev_t[ev_n] = T_ABT;
                ev_d[ev_n] = 8'h00;
                ev_id[ev_n] = 16'h0;
                ev_n++;
            end
            if (frm_err) frm_cnt++;
            if (ovr_err) ovr_cnt++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_ev(input string req, input int idx, input int t, input int dat);
        chk(req, $sformatf("event %0d type", idx), ev_t[idx], t);
        if (t != T_ABT) chk(req, $sformatf("event %0d data", idx), ev_d[idx], dat);
    endtask

    function automatic bit exp_match(input logic [15:0] id);
        bit r = 0;
        for (int k = 0; k < 4; k++)
            if (m_en[k] && (((id ^ m_val[k]) & m_msk[k]) == 16'h0)) r = 1;
        return r;
    endfunction

    task automatic wr_flt(input int idx, input bit en, input logic [15:0] v, input logic [15:0] m);
        m_en[idx] = en; m_val[idx] = v; m_msk[idx] = m;
        @(negedge clk);
        flt_wr = 1'b1; flt_idx = 2'(idx); flt_en = en; flt_val = v; flt_mask = m;
        @(negedge clk);
        flt_wr = 1'b0;
    endtask

    // one character; noisy flips 8 of 16 samples (2 inside the vote window) of data bits
    task automatic send_byte(input logic [7:0] b, input bit stop = 1'b1,
                             input bit noisy = 1'b0, input int gap = 0);
        for (int s = 0; s < 16; s++) begin rx = 1'b0; @(negedge clk); end
        for (int i = 0; i < 8; i++) begin
            for (int s = 0; s < 16; s++) begin
                rx = b[i];
                if (noisy && (s == 1 || s == 2 || s == 3 || s == 6 || s == 7 ||
                              s == 12 || s == 13 || s == 14)) rx = ~b[i];
                @(negedge clk);
            end
        end
        for (int s = 0; s < 16; s++) begin rx = stop; @(negedge clk); end
        rx = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        for (int k = 0; k < 4; k++) begin m_en[k] = 0; m_val[k] = 0; m_msk[k] = 0; end
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "out_valid", int'(out_valid), 0);
        chk("R12", "out_abort", int'(out_abort), 0);
        chk("R12", "errors", int'({frm_err, ovr_err}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R6: all entries disabled after reset, nothing accepted
        base = ev_n;
        send_byte(SOM); send_byte(8'h03); send_byte(EOM, 1'b1, 1'b0, 4);
        chk("R6", "events with empty table", ev_n - base, 0);

        wr_flt(0, 1, 16'h00A0, 16'h00F0);
        wr_flt(1, 1, 16'h0003, 16'h00FF);
        wr_flt(2, 0, 16'h0050, 16'h00F0);
        wr_flt(3, 1, 16'h00C1, 16'h00C3);

        // R6 R5 R1: sweep every one-byte identifier
        for (int id = 0; id < 256; id++) begin
            bit e;
            base = ev_n;
            e = (8'(id) != SOM) && exp_match({8'h00, 8'(id)});
            send_byte(SOM); send_byte(8'(id)); send_byte(EOM, 1'b1, 1'b0, 2);
            if (e) begin
                chk("R6", $sformatf("accept id %0h count", id), ev_n - base, 2);
                chk("R5", $sformatf("accept id %0h out_id", id), int'(ev_id[base]), id);
                chk("R4", $sformatf("accept id %0h eop", id), ev_t[base+1], T_EOP);
            end else begin
                chk("R6", $sformatf("reject id %0h count", id), ev_n - base, 0);
            end
        end

        // R5 R7 R4: two identifier bytes, payload, long gaps
        wr_flt(1, 1, 16'h1234, 16'hFFFF);
        id_two = 1'b1;
        base = ev_n;
        send_byte(SOM, 1, 0, 37); send_byte(8'h12, 1, 0, 500); send_byte(8'h34);
        send_byte(8'h11, 1, 0, 3); send_byte(8'h22, 1, 0, 1000); send_byte(8'h33);
        send_byte(EOM, 1, 0, 4);
        chk("R7", "two-id event count", ev_n - base, 5);
        chk_ev("R4", base, T_SOP, 8'h34);
        chk("R5", "two-id out_id", int'(ev_id[base]), 16'h1234);
        chk_ev("R4", base+1, T_DAT, 8'h11);
        chk_ev("R7", base+2, T_DAT, 8'h22);
        chk_ev("R4", base+3, T_DAT, 8'h33);
        chk_ev("R4", base+4, T_EOP, EOM);
        // R6: two-id mismatch in the low byte
        base = ev_n;
        send_byte(SOM); send_byte(8'h12); send_byte(8'h35); send_byte(8'h01); send_byte(EOM, 1, 0, 4);
        chk("R6", "two-id reject", ev_n - base, 0);
        id_two = 1'b0;

        // R8: bytes outside a message ignored
        base = ev_n;
        send_byte(8'hA1); send_byte(8'h11); send_byte(EOM, 1, 0, 4);
        chk("R8", "junk between messages", ev_n - base, 0);
        send_byte(SOM); send_byte(8'hA1); send_byte(EOM, 1, 0, 4);
        chk("R8", "message after junk", ev_n - base, 2);

        // R2: noise tolerance on payload bits
        base = ev_n;
        send_byte(SOM); send_byte(8'hA3);
        send_byte(8'h96, 1, 1); send_byte(8'h3C, 1, 1); send_byte(EOM, 1, 0, 4);
        chk("R2", "noisy event count", ev_n - base, 4);
        chk_ev("R2", base+1, T_DAT, 8'h96);
        chk_ev("R2", base+2, T_DAT, 8'h3C);

        // R3: short glitch is not a start bit
        base = ev_n;
        rx = 1'b0; repeat (5) @(negedge clk); rx = 1'b1; repeat (40) @(negedge clk);
        chk("R3", "glitch events", ev_n - base, 0);
        chk("R3", "glitch framing errors", frm_cnt, 0);
        send_byte(SOM); send_byte(8'hA2); send_byte(EOM, 1, 0, 4);
        chk("R3", "message after glitch", ev_n - base, 2);

        // R9: dominant stop bit discards accepted message
        base = ev_n;
        send_byte(SOM); send_byte(8'hA4); send_byte(8'h33);
        send_byte(8'h44, 1'b0, 1'b0, 30);
        send_byte(8'h55); send_byte(EOM, 1, 0, 4);
        chk("R9", "framing error count", frm_cnt, 1);
        chk("R9", "frame error events", ev_n - base, 3);
        chk_ev("R9", base+1, T_DAT, 8'h33);
        chk_ev("R9", base+2, T_ABT, 0);

        // R10: start code restarts framing
        base = ev_n;
        send_byte(SOM); send_byte(8'hA6); send_byte(8'h01);
        send_byte(SOM); send_byte(8'hA7); send_byte(EOM, 1, 0, 4);
        chk("R10", "restart events", ev_n - base, 5);
        chk_ev("R10", base+2, T_ABT, 0);
        chk_ev("R10", base+3, T_SOP, 8'hA7);
        chk("R10", "restart out_id", int'(ev_id[base+3]), 16'h00A7);
        chk_ev("R10", base+4, T_EOP, EOM);

        // R11: exactly MAX_LEN payload bytes allowed
        base = ev_n;
        send_byte(SOM); send_byte(8'hA8);
        for (int i = 0; i < 8; i++) send_byte(8'(i + 8'h20));
        send_byte(EOM, 1, 0, 4);
        chk("R11", "max length events", ev_n - base, 10);
        chk_ev("R11", base+8, T_DAT, 8'h27);
        chk_ev("R11", base+9, T_EOP, EOM);
        chk("R11", "no overrun at limit", ovr_cnt, 0);
        // R11: one more byte overruns
        base = ev_n;
        send_byte(SOM); send_byte(8'hA9);
        for (int i = 0; i < 9; i++) send_byte(8'(i + 8'h40));
        send_byte(EOM, 1, 0, 4);
        chk("R11", "overrun count", ovr_cnt, 1);
        chk("R11", "overrun events", ev_n - base, 10);
        chk_ev("R11", base+9, T_ABT, 0);
        // R11: overrun on a rejected message flags but does not abort
        base = ev_n;
        send_byte(SOM); send_byte(8'h10);
        for (int i = 0; i < 9; i++) send_byte(8'h61);
        send_byte(EOM, 1, 0, 4);
        chk("R11", "rejected overrun count", ovr_cnt, 2);
        chk("R11", "rejected overrun events", ev_n - base, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule